// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Slice

This block is the interrupt logic that one peripheral on an 8-bit processor bus needs to take part in a serial priority chain. Internal logic raises a one-cycle request. The slice then latches the request as pending and enables the pull-down of the shared open-drain interrupt line. Priority comes from position in the chain. A device passes permission downstream on `ieo_o` only while nothing of its own is pending or being serviced, and it may claim a cycle only while `iei_i` is high.

During an interrupt acknowledge bus cycle, the device that holds a pending request and sees `iei_i` high claims the cycle. It drives its vector byte onto the data bus for the whole cycle and moves the request from pending to under service. An under-service device holds `ieo_o` low until the service routine returns. The slice detects the return by watching opcode fetches for the two-byte return sequence. After the prefix byte is fetched, a device that is only pending releases its hold on the chain. This leaves the serviced device as the only one with permission in and none out, so only that device clears its under-service state on the second byte.

Bus strobes are active low and synchronous to `clk_i`.

Top module: `dc_intr_slice`

## Requirements
- R1: An active-low `rst_ni` clears the pending and under-service state at once. While reset is held and afterwards, `irq_o` is 0, `data_oe_o` is 0 and `ieo_o` equals `iei_i`.
- R2: A cycle with `req_i`=1 sets the pending state at the next clock edge. `irq_o` is 1 exactly when a request is pending, none is under service and `iei_i` is 1.
- R3: `ieo_o` is never 1 while `iei_i` is 0. With nothing pending and nothing under service, `ieo_o` follows `iei_i`. With a request pending and no prefix seen, `ieo_o` is 0.
- R4: An acknowledge cycle is `m1_ni`=0, `iorq_ni`=0, `rd_ni`=1. If `iei_i`=1 and a request is pending in its first clock, the slice drives `data_oe_o`=1 with `data_o`=`vec_i` for every clock of that cycle. At the first edge the pending state moves to under service.
- R5: An acknowledge cycle that starts with `iei_i`=0 leaves `data_oe_o` at 0, leaves `data_o` at 0 and keeps the request pending.
- R6: While a request is under service, `ieo_o` is 0 and `irq_o` is 0, whatever `iei_i` is.
- R7: After an opcode fetch (`m1_ni`=0, `rd_ni`=0, `iorq_ni`=1) of byte 0xED, a pending-only slice drives `ieo_o`=`iei_i` until the next opcode fetch begins.
- R8: A fetch of 0x4D as the next opcode after 0xED, with `iei_i`=1 and a request under service, clears the under-service state at that edge.
- R9: The under-service state is kept when the byte after 0xED is not 0x4D, or when `iei_i` is 0 during the 0x4D fetch.
- R10: The opcode is sampled only in the first clock of each fetch cycle. Bytes seen in later clocks of the same fetch are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Interrupt request pulse from internal logic |
| vec_i | input | 8 | Vector byte placed on the bus at acknowledge |
| m1_ni | input | 1 | Opcode-fetch / acknowledge strobe, active low |
| iorq_ni | input | 1 | I/O request strobe, active low |
| rd_ni | input | 1 | Read strobe, active low |
| data_i | input | 8 | Data bus as seen by the slice |
| iei_i | input | 1 | Chain enable from the higher-priority neighbour |
| ieo_o | output | 1 | Chain enable to the lower-priority neighbour |
| irq_o | output | 1 | Pull-down enable for the open-drain interrupt line |
| data_o | output | 8 | Vector byte, zero when not driving |
| data_oe_o | output | 1 | Data bus output enable |

## Verification
The bench goes after the return sequence's edge cases. It fetches 0x4D in a later clock of the same fetch that carried 0xED. A slice that samples every clock would clear its service state too early and open `ieo_o` on the next row. It fetches 0x4D with `iei_i` low, and it fetches a wrong second byte. A slice that ignored either condition would let lower devices through while it is still in service. It holds a pending request across a prefix fetch to show the temporary release of the chain. A design without that release would keep `ieo_o` low. It starts an acknowledge with `iei_i` low, which must neither drive the bus nor consume the request. It also checks that a reset in the middle of service clears both latches at once.

// File: rtl/dc_pkg.sv
package dc_pkg;
  typedef enum logic [0:0] {
    SNOOP_IDLE   = 1'b0,
    SNOOP_PREFIX = 1'b1
  } snoop_st_e;
endpackage

// File: rtl/dc_bus_cycle.sv
module dc_bus_cycle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic m1_ni,
  input  logic iorq_ni,
  input  logic rd_ni,
  output logic fetch_start_o,
  output logic ack_act_o,
  output logic ack_start_o
);
  logic fetch_act, fetch_q, ack_q;

  assign fetch_act = !m1_ni && !rd_ni && iorq_ni;
  assign ack_act_o = !m1_ni && !iorq_ni && rd_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      fetch_q <= fetch_act;
      ack_q   <= ack_act_o;
    end
  end

  // first clock of each bus cycle only
  assign fetch_start_o = fetch_act && !fetch_q;
  assign ack_start_o   = ack_act_o && !ack_q;
endmodule

// File: rtl/dc_ret_snoop.sv
module dc_ret_snoop #(
  parameter int unsigned         DATA_W    = 8,
  parameter logic [DATA_W-1:0]   PREFIX_OP = 8'hED,
  parameter logic [DATA_W-1:0]   RET_OP    = 8'h4D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fetch_start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              prefix_seen_o,
  output logic              ret_hit_o
);
  import dc_pkg::*;

  snoop_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (fetch_start_i) begin
      if (st_q == SNOOP_IDLE && data_i == PREFIX_OP) st_d = SNOOP_PREFIX;
      else                                           st_d = SNOOP_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= SNOOP_IDLE;
    else         st_q <= st_d;
  end

  assign prefix_seen_o = (st_q == SNOOP_PREFIX);
  assign ret_hit_o     = prefix_seen_o && fetch_start_i && (data_i == RET_OP);
endmodule

// File: rtl/dc_prio_latch.sv
module dc_prio_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic iei_i,
  input  logic ack_act_i,
  input  logic ack_start_i,
  input  logic ret_hit_i,
  input  logic prefix_seen_i,
  output logic pend_o,
  output logic ius_o,
  output logic claim_o,
  output logic irq_o,
  output logic ieo_o
);
  logic pend_q, ius_q, own_q;
  logic take, release_ius;

  assign take        = ack_start_i && iei_i && pend_q;
  assign release_ius = ret_hit_i && iei_i && ius_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ius_q  <= 1'b0;
      own_q  <= 1'b0;
    end else begin
      pend_q <= (pend_q && !take) || req_i;
      if (take)             ius_q <= 1'b1;
      else if (release_ius) ius_q <= 1'b0;
      if (take)             own_q <= 1'b1;
      else if (!ack_act_i)  own_q <= 1'b0;
    end
  end

  assign claim_o = take || (ack_act_i && own_q);
  assign irq_o   = pend_q && iei_i && !ius_q;
  // pending-only device releases chain after prefix fetch
  assign ieo_o   = iei_i && !ius_q && (!pend_q || prefix_seen_i);
  assign pend_o  = pend_q;
  assign ius_o   = ius_q;
endmodule

// File: rtl/dc_intr_slice.sv
module dc_intr_slice #(
  parameter int unsigned       DATA_W    = 8,
  parameter logic [DATA_W-1:0] PREFIX_OP = 8'hED,
  parameter logic [DATA_W-1:0] RET_OP    = 8'h4D
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [DATA_W-1:0] vec_i,
  input  logic              m1_ni,
  input  logic              iorq_ni,
  input  logic              rd_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              iei_i,
  output logic              ieo_o,
  output logic              irq_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  logic fetch_start, ack_act, ack_start;
  logic prefix_seen, ret_hit;
  logic pend_q, ius_q, claim;

  dc_bus_cycle u_bus (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .m1_ni         (m1_ni),
    .iorq_ni       (iorq_ni),
    .rd_ni         (rd_ni),
    .fetch_start_o (fetch_start),
    .ack_act_o     (ack_act),
    .ack_start_o   (ack_start)
  );

  dc_ret_snoop #(
    .DATA_W    (DATA_W),
    .PREFIX_OP (PREFIX_OP),
    .RET_OP    (RET_OP)
  ) u_snoop (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fetch_start_i (fetch_start),
    .data_i        (data_i),
    .prefix_seen_o (prefix_seen),
    .ret_hit_o     (ret_hit)
  );

  dc_prio_latch u_latch (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (req_i),
    .iei_i         (iei_i),
    .ack_act_i     (ack_act),
    .ack_start_i   (ack_start),
    .ret_hit_i     (ret_hit),
    .prefix_seen_i (prefix_seen),
    .pend_o        (pend_q),
    .ius_o         (ius_q),
    .claim_o       (claim),
    .irq_o         (irq_o),
    .ieo_o         (ieo_o)
  );

  assign data_oe_o = claim;
  assign data_o    = claim ? vec_i : '0;
endmodule

// File: rtl/dc_intr_slice_chk.sv
module dc_intr_slice_chk #(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] RET_OP = 8'h4D
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              m1_ni,
  input logic              iorq_ni,
  input logic              rd_ni,
  input logic              iei_i,
  input logic [DATA_W-1:0] data_i,
  input logic              ieo_o,
  input logic              irq_o,
  input logic              data_oe_o,
  input logic              pend_q,
  input logic              ius_q,
  input logic              prefix_seen,
  input logic              fetch_start,
  input logic              ack_start
);
  p_ieo_needs_iei_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ieo_o |-> iei_i);

  p_oe_only_in_ack_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (!m1_ni && !iorq_ni && rd_ni));

  p_take_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start && iei_i && pend_q) |=> ius_q);

  p_no_claim_low_iei_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_start && !iei_i && !ius_q) |-> !data_oe_o);

  p_service_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ius_q |-> (!ieo_o && !irq_o));

  p_return_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prefix_seen && fetch_start && data_i == RET_OP && iei_i && ius_q) |=> !ius_q);

  p_low_iei_keeps_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ius_q && !iei_i && !ack_start) |=> ius_q);
endmodule

bind dc_intr_slice dc_intr_slice_chk #(
  .DATA_W (DATA_W),
  .RET_OP (RET_OP)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .m1_ni       (m1_ni),
  .iorq_ni     (iorq_ni),
  .rd_ni       (rd_ni),
  .iei_i       (iei_i),
  .data_i      (data_i),
  .ieo_o       (ieo_o),
  .irq_o       (irq_o),
  .data_oe_o   (data_oe_o),
  .pend_q      (pend_q),
  .ius_q       (ius_q),
  .prefix_seen (prefix_seen),
  .fetch_start (fetch_start),
  .ack_start   (ack_start)
);

// File: tb/tb_dc_intr_slice.sv
module tb_dc_intr_slice;
  localparam logic [7:0] VEC = 8'hA6;
  localparam int NROW = 33;
  // {tag[3:0], req, m1n, iorqn, rdn, iei, data[7:0], exp irq, exp ieo, exp oe}
  // strobes: 111 idle, 001 acknowledge, 010 opcode fetch
  localparam logic [19:0] TBL [NROW] = '{
    {4'd3,  1'b0, 3'b111, 1'b1, 8'h00, 3'b010}, // 0  R3 idle follows iei
    {4'd2,  1'b1, 3'b111, 1'b1, 8'h00, 3'b010}, // 1  R2 request
    {4'd2,  1'b0, 3'b111, 1'b1, 8'h00, 3'b100}, // 2  R2 pending
    {4'd3,  1'b0, 3'b111, 1'b0, 8'h00, 3'b000}, // 3  R3 iei low
    {4'd4,  1'b0, 3'b001, 1'b1, 8'h00, 3'b101}, // 4  R4 ack first clock
    {4'd4,  1'b0, 3'b001, 1'b1, 8'h00, 3'b001}, // 5  R4 ack held
    {4'd6,  1'b0, 3'b111, 1'b1, 8'h00, 3'b000}, // 6  R6 in service
    {4'd6,  1'b0, 3'b010, 1'b1, 8'hED, 3'b000}, // 7  R6 prefix fetch
    {4'd10, 1'b0, 3'b010, 1'b1, 8'h4D, 3'b000}, // 8  R10 same fetch, ignored
    {4'd10, 1'b0, 3'b111, 1'b1, 8'h00, 3'b000}, // 9  R10 still in service
    {4'd8,  1'b0, 3'b010, 1'b1, 8'h4D, 3'b000}, // 10 R8 return byte
    {4'd8,  1'b0, 3'b111, 1'b1, 8'h00, 3'b010}, // 11 R8 cleared
    {4'd2,  1'b1, 3'b111, 1'b1, 8'h00, 3'b010}, // 12 R2 request
    {4'd7,  1'b0, 3'b010, 1'b1, 8'hED, 3'b100}, // 13 R7 prefix while pending
    {4'd7,  1'b0, 3'b111, 1'b1, 8'h00, 3'b110}, // 14 R7 chain released
    {4'd7,  1'b0, 3'b010, 1'b1, 8'h00, 3'b110}, // 15 R7 next fetch
    {4'd7,  1'b0, 3'b111, 1'b1, 8'h00, 3'b100}, // 16 R7 release ends
    {4'd5,  1'b0, 3'b001, 1'b0, 8'h00, 3'b000}, // 17 R5 ack, iei low
    {4'd5,  1'b0, 3'b111, 1'b1, 8'h00, 3'b100}, // 18 R5 still pending
    {4'd4,  1'b0, 3'b001, 1'b1, 8'h00, 3'b101}, // 19 R4 ack
    {4'd6,  1'b0, 3'b111, 1'b1, 8'h00, 3'b000}, // 20 R6
    {4'd9,  1'b0, 3'b010, 1'b1, 8'hED, 3'b000}, // 21 R9
    {4'd9,  1'b0, 3'b111, 1'b1, 8'h00, 3'b000}, // 22 R9
    {4'd9,  1'b0, 3'b010, 1'b0, 8'h4D, 3'b000}, // 23 R9 return byte, iei low
    {4'd9,  1'b0, 3'b111, 1'b1, 8'h00, 3'b000}, // 24 R9 kept
    {4'd9,  1'b0, 3'b010, 1'b1, 8'hED, 3'b000}, // 25 R9
    {4'd9,  1'b0, 3'b111, 1'b1, 8'h00, 3'b000}, // 26 R9
    {4'd9,  1'b0, 3'b010, 1'b1, 8'h55, 3'b000}, // 27 R9 wrong byte
    {4'd9,  1'b0, 3'b111, 1'b1, 8'h00, 3'b000}, // 28 R9 kept
    {4'd8,  1'b0, 3'b010, 1'b1, 8'hED, 3'b000}, // 29 R8
    {4'd8,  1'b0, 3'b111, 1'b1, 8'h00, 3'b000}, // 30 R8
    {4'd8,  1'b0, 3'b010, 1'b1, 8'h4D, 3'b000}, // 31 R8
    {4'd8,  1'b0, 3'b111, 1'b1, 8'h00, 3'b010}  // 32 R8 cleared
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, m1_ni = 1'b1, iorq_ni = 1'b1, rd_ni = 1'b1, iei_i = 1'b1;
  logic [7:0] vec_i = VEC, data_i = 8'h00;
  logic ieo_o, irq_o, data_oe_o;
  logic [7:0] data_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dc_intr_slice dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .vec_i(vec_i),
    .m1_ni(m1_ni), .iorq_ni(iorq_ni), .rd_ni(rd_ni), .data_i(data_i),
    .iei_i(iei_i), .ieo_o(ieo_o), .irq_o(irq_o), .data_o(data_o),
    .data_oe_o(data_oe_o)
  );

  task automatic check(input string tag, input logic [2:0] exp);
    logic [7:0] exp_d;
    exp_d = exp[0] ? VEC : 8'h00;
    total++;
    if ({irq_o, ieo_o, data_oe_o} !== exp || data_o !== exp_d) begin
      bad++;
      $display("FAIL %s irq/ieo/oe=%b data=%h expected %b data=%h",
               tag, {irq_o, ieo_o, data_oe_o}, data_o, exp, exp_d);
    end
  endtask

  task automatic drive(input logic r, input logic [2:0] s, input logic ei, input logic [7:0] d);
    req_i = r; {m1_ni, iorq_ni, rd_ni} = s; iei_i = ei; data_i = d;
  endtask

  initial begin
    #1;
    check("R1 in reset", 3'b010);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      drive(TBL[i][15], TBL[i][14:12], TBL[i][11], TBL[i][10:3]);
      #2;
      check($sformatf("R%0d row %0d", TBL[i][19:16], i), TBL[i][2:0]);
    end
    // R1: reset in mid service with a new request pending
    @(negedge clk); drive(1'b1, 3'b111, 1'b1, 8'h00);
    @(negedge clk); drive(1'b0, 3'b001, 1'b1, 8'h00);
    @(negedge clk); drive(1'b1, 3'b111, 1'b1, 8'h00);
    @(negedge clk); drive(1'b0, 3'b111, 1'b1, 8'h00);
    #2; check("R1 pre-reset in service", 3'b000);
    #1; rst_ni = 1'b0; #1;
    check("R1 async clear", 3'b010);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #2;
    check("R1 after release", 3'b010);
    drive(1'b0, 3'b111, 1'b0, 8'h00); #1;
    check("R1 ieo tracks iei", 3'b000);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule